// File: doc/BRIEF.md
# Ancillary Packet Insertion Scheduler

This block decides, one blanking region at a time, whether a pending ancillary data packet may be placed into a 10-bit digital video stream and at which word. An upstream parser does not hand over packet contents. It sends a short summary of each region on the region's first word: the region length in words, the offset just past the last conforming packet, whether a start-marker or an end-marker packet is present, the offset of the end-marker, and whether the region carries an error-detection (EDH) packet. From this summary the block works out where free space begins and how many words remain. It then compares that count with the length of the pending packet.

Software or a packet generator loads a request with a length and two permission flags, one for the horizontal region and one for the vertical region, and pulses a ready strobe. The request waits until a region has room for it, honouring the keep-out regions around the synchronous-switching line. When such a region arrives, the block raises a one-cycle start pulse, reports the region kind and the offset it picked, and holds a busy flag for as many cycles as the packet has words. Within a line the horizontal region is presented before the vertical one. A packet allowed in both regions that does not fit in the horizontal region therefore falls into the vertical region of the same line.

Top module: `anc_ins_sched`

## Requirements
- R1: A packet is started in a region only if its length is no greater than the free word count of that region. With equal counts it is accepted, and with one word too few it is refused.
- R2: Free space begins at the end-marker offset when an end-marker is flagged, because the marker's own words are reusable. Otherwise it begins at the offset after the last conforming packet. It runs to the region end.
- R3: A region flagged with a start-marker and no end-marker has no free space, because everything after the start-marker is occupied.
- R4: When the region is flagged as holding an EDH packet, EDH_WORDS (default 23) words are subtracted from the free count. A result below zero counts as zero.
- R5: With switch line S, no insertion happens in the vertical region of line S or in the horizontal region of line S+1.
- R6: A packet is placed only in a region kind it is permitted for. A packet permitted in both kinds that does not fit the horizontal region is placed in the vertical region of the same line when it fits there.
- R7: A packet that is not placed stays pending, and `pending`=1, and is retried in every later region until it is placed.
- R8: `ins_start` is high for one cycle, one clock after the region word at the free-space offset is presented. `ins_off` then gives that offset counted from the region's first word (0). `ins_vanc` gives the region kind (1 = vertical).
- R9: `ins_busy` rises together with `ins_start` and stays high for exactly the packet length in cycles.
- R10: A ready strobe is ignored while a request is pending or a packet is being sent. A strobe with length 0 is ignored.
- R11: Reset clears the pending request, the sending state and the region tracking. All outputs are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| line_num | input | LINE_W | Current line number |
| switch_line | input | LINE_W | Synchronous-switching line S |
| hpos | input | 12 | Horizontal word position |
| in_region | input | 1 | High on every word of an ancillary region |
| region_is_vanc | input | 1 | Region kind: 1 vertical, 0 horizontal |
| sum_len | input | 12 | Region length in words, valid on the first word |
| sum_conf_end | input | 12 | Offset after last conforming packet |
| sum_has_open | input | 1 | Start-marker packet present |
| sum_has_close | input | 1 | End-marker packet present |
| sum_close_off | input | 12 | Offset of end-marker packet |
| sum_edh | input | 1 | Region holds an EDH packet |
| pkt_ready | input | 1 | Request strobe |
| pkt_len | input | 10 | Packet length in words |
| allow_hanc | input | 1 | Packet may go in horizontal region |
| allow_vanc | input | 1 | Packet may go in vertical region |
| ins_start | output | 1 | Insertion start pulse |
| ins_busy | output | 1 | Packet words being inserted |
| ins_vanc | output | 1 | Kind of region used |
| ins_off | output | 12 | Offset of insertion within region |
| pending | output | 1 | Request waiting for space |

## Verification
The summary is sampled on the first word of a region. A fit decision made there becomes visible on `ins_start` one clock after the word at the chosen offset, and `ins_busy` covers the same cycle and the following packet-length minus one cycles. The bench samples on the falling edge. It records the position of the word that was presented one cycle before each observed start pulse and compares that position with the region base plus the expected offset. It measures the busy run only after the run has ended. `pending` is read after the region's trailing gap, by which time a refusal or an acceptance has settled.

// File: rtl/anc_sched_pkg.sv
package anc_sched_pkg;

    localparam int OFF_W = 12;
    localparam int LEN_W = 10;

    typedef logic [OFF_W-1:0] off_t;
    typedef logic [LEN_W-1:0] len_t;

    // Region summary presented on the first word of a region
    typedef struct packed {
        off_t rlen;       // region length in words
        off_t conf_end;   // offset after last conforming packet
        logic has_open;   // start-marker present
        logic has_close;  // end-marker present
        off_t close_off;  // offset of end-marker packet
        logic edh_in;     // EDH packet lives in this region
    } region_sum_t;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_PEND  = 2'd1,
        SQ_ARMED = 2'd2,
        SQ_SEND  = 2'd3
    } seq_state_t;

    // First reusable word of a region
    function automatic off_t free_origin(region_sum_t s);
        if (s.has_close)
            return s.close_off;
        else if (s.has_open)
            return s.rlen;
        else
            return s.conf_end;
    endfunction

    // Words left for a new packet, never negative
    function automatic off_t free_words(region_sum_t s, off_t edh_words);
        logic [OFF_W:0] used;
        used = {1'b0, free_origin(s)} + {1'b0, (s.edh_in ? edh_words : off_t'(0))};
        if (used >= {1'b0, s.rlen})
            return '0;
        else
            return s.rlen - used[OFF_W-1:0];
    endfunction

endpackage

// File: rtl/anc_region_track.sv
module anc_region_track
    import anc_sched_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_region,
    input  off_t hpos,
    output logic first,
    output off_t cur_off
);

    logic in_q;
    off_t base_q;

    assign first   = in_region & ~in_q;
    assign cur_off = first ? off_t'(0) : off_t'(hpos - base_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            in_q   <= 1'b0;
            base_q <= '0;
        end else begin
            in_q <= in_region;
            if (first)
                base_q <= hpos;
        end
    end

    // R8: a region start is a single word
    p_first_single_r8: assert property (@(posedge clk) disable iff (rst)
        first |=> !first);

endmodule

// File: rtl/anc_space_calc.sv
module anc_space_calc
    import anc_sched_pkg::*;
#(
    parameter int EDH_WORDS = 23
) (
    input  region_sum_t sum,
    input  len_t        len,
    output off_t        origin,
    output off_t        free_cnt,
    output logic        fits
);

    localparam off_t EDH_OFF = off_t'(EDH_WORDS);

    always_comb begin
        origin   = free_origin(sum);
        free_cnt = free_words(sum, EDH_OFF);
        fits     = (off_t'(len) <= free_cnt);
    end

endmodule

// File: rtl/anc_ins_seq.sv
module anc_ins_seq
    import anc_sched_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pkt_ready,
    input  len_t pkt_len,
    input  logic allow_hanc,
    input  logic allow_vanc,
    input  logic first,
    input  logic in_region,
    input  logic is_vanc,
    input  logic keepout,
    input  logic fits,
    input  off_t origin,
    input  off_t cur_off,
    output len_t len_q,
    output logic ins_start,
    output logic ins_busy,
    output logic ins_vanc,
    output off_t ins_off,
    output logic pending
);

    seq_state_t state;
    logic       ah_q, av_q, vanc_q;
    off_t       tgt_q;
    len_t       rem_q;
    logic       allowed, cand, hit_now, hit_arm, hit;

    always_comb begin
        allowed = is_vanc ? av_q : ah_q;
        cand    = first && (state == SQ_PEND) && allowed && !keepout && fits;
        hit_now = cand && (origin == '0);
        hit_arm = (state == SQ_ARMED) && in_region && !first && (cur_off == tgt_q);
        hit     = hit_now || hit_arm;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SQ_IDLE;
            len_q     <= '0;
            ah_q      <= 1'b0;
            av_q      <= 1'b0;
            vanc_q    <= 1'b0;
            tgt_q     <= '0;
            rem_q     <= '0;
            ins_start <= 1'b0;
            ins_vanc  <= 1'b0;
            ins_off   <= '0;
        end else begin
            ins_start <= hit;
            if (hit) begin
                rem_q    <= len_q - len_t'(1);
                ins_vanc <= hit_arm ? vanc_q : is_vanc;
                ins_off  <= hit_arm ? tgt_q : off_t'(0);
            end
            unique case (state)
                SQ_IDLE: begin
                    if (pkt_ready && (pkt_len != '0)) begin
                        state <= SQ_PEND;
                        len_q <= pkt_len;
                        ah_q  <= allow_hanc;
                        av_q  <= allow_vanc;
                    end
                end
                SQ_PEND: begin
                    if (hit_now) begin
                        state <= SQ_SEND;
                    end else if (cand) begin
                        state  <= SQ_ARMED;
                        tgt_q  <= origin;
                        vanc_q <= is_vanc;
                    end
                end
                SQ_ARMED: begin
                    if (hit_arm)
                        state <= SQ_SEND;
                    else if (!in_region)
                        state <= SQ_PEND;
                end
                SQ_SEND: begin
                    if (rem_q == '0)
                        state <= SQ_IDLE;
                    else
                        rem_q <= rem_q - len_t'(1);
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign ins_busy = (state == SQ_SEND);
    assign pending  = (state == SQ_PEND) || (state == SQ_ARMED);

    // R9: busy begins with the start pulse
    p_start_busy_r9: assert property (@(posedge clk) disable iff (rst)
        ins_start |-> ins_busy);
    // R8: start is a single-cycle pulse
    p_start_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        ins_start |=> !ins_start);
    // R10: the request length does not change while waiting
    p_len_hold_r10: assert property (@(posedge clk) disable iff (rst)
        pending && pkt_ready |=> $stable(len_q));
    // R10: no waiting request while a packet is sent
    p_busy_excl_r10: assert property (@(posedge clk) disable iff (rst)
        ins_busy |-> !pending);

endmodule

// File: rtl/anc_ins_sched.sv
module anc_ins_sched
    import anc_sched_pkg::*;
#(
    parameter int LINE_W    = 11,
    parameter int EDH_WORDS = 23
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINE_W-1:0] line_num,
    input  logic [LINE_W-1:0] switch_line,
    input  logic [11:0]       hpos,
    input  logic              in_region,
    input  logic              region_is_vanc,
    input  logic [11:0]       sum_len,
    input  logic [11:0]       sum_conf_end,
    input  logic              sum_has_open,
    input  logic              sum_has_close,
    input  logic [11:0]       sum_close_off,
    input  logic              sum_edh,
    input  logic              pkt_ready,
    input  logic [9:0]        pkt_len,
    input  logic              allow_hanc,
    input  logic              allow_vanc,
    output logic              ins_start,
    output logic              ins_busy,
    output logic              ins_vanc,
    output logic [11:0]       ins_off,
    output logic              pending
);

    localparam logic [LINE_W-1:0] LINE_ONE = LINE_W'(1);

    region_sum_t sum;
    logic        first, fits, keepout;
    off_t        cur_off, origin, free_cnt;
    len_t        len_q;

    always_comb begin
        sum.rlen      = sum_len;
        sum.conf_end  = sum_conf_end;
        sum.has_open  = sum_has_open;
        sum.has_close = sum_has_close;
        sum.close_off = sum_close_off;
        sum.edh_in    = sum_edh;
        keepout = region_is_vanc ? (line_num == switch_line)
                                 : (line_num == switch_line + LINE_ONE);
    end

    anc_region_track u_track (
        .clk       (clk),
        .rst       (rst),
        .in_region (in_region),
        .hpos      (hpos),
        .first     (first),
        .cur_off   (cur_off)
    );

    anc_space_calc #(.EDH_WORDS(EDH_WORDS)) u_space (
        .sum      (sum),
        .len      (len_q),
        .origin   (origin),
        .free_cnt (free_cnt),
        .fits     (fits)
    );

    anc_ins_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .pkt_ready  (pkt_ready),
        .pkt_len    (pkt_len),
        .allow_hanc (allow_hanc),
        .allow_vanc (allow_vanc),
        .first      (first),
        .in_region  (in_region),
        .is_vanc    (region_is_vanc),
        .keepout    (keepout),
        .fits       (fits),
        .origin     (origin),
        .cur_off    (cur_off),
        .len_q      (len_q),
        .ins_start  (ins_start),
        .ins_busy   (ins_busy),
        .ins_vanc   (ins_vanc),
        .ins_off    (ins_off),
        .pending    (pending)
    );

    // R5: no vertical-region start on the switch line
    p_keepout_v_r5: assert property (@(posedge clk) disable iff (rst)
        ins_start && ins_vanc |-> $past(line_num) != $past(switch_line));
    // R5: no horizontal-region start on the line after it
    p_keepout_h_r5: assert property (@(posedge clk) disable iff (rst)
        ins_start && !ins_vanc |-> $past(line_num) != $past(switch_line) + LINE_ONE);
    // R11: reset leaves nothing waiting or sending
    p_reset_clear_r11: assert property (@(posedge clk)
        $past(rst) |-> !pending && !ins_busy && !ins_start);

endmodule

// File: tb/tb_anc_ins_sched.sv
`timescale 1ns/1ps
module tb_anc_ins_sched;

    localparam int EDHW = 23;
    localparam int SWL  = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] line_num = '0;
    logic [10:0] switch_line = 11'(SWL);
    logic [11:0] hpos = '0;
    logic        in_region = 1'b0;
    logic        region_is_vanc = 1'b0;
    logic [11:0] sum_len = '0, sum_conf_end = '0, sum_close_off = '0;
    logic        sum_has_open = 1'b0, sum_has_close = 1'b0, sum_edh = 1'b0;
    logic        pkt_ready = 1'b0;
    logic [9:0]  pkt_len = '0;
    logic        allow_hanc = 1'b0, allow_vanc = 1'b0;
    logic        ins_start, ins_busy, ins_vanc, pending;
    logic [11:0] ins_off;

    int errs = 0, checks = 0;
    int n_starts = 0, rec_hpos = 0, rec_off = 0, rec_vanc = 0;
    int busy_run = 0, last_busy = 0, last_hpos = 0;

    always #2.5 clk = ~clk;

    anc_ins_sched dut (
        .clk(clk), .rst(rst), .line_num(line_num), .switch_line(switch_line),
        .hpos(hpos), .in_region(in_region), .region_is_vanc(region_is_vanc),
        .sum_len(sum_len), .sum_conf_end(sum_conf_end), .sum_has_open(sum_has_open),
        .sum_has_close(sum_has_close), .sum_close_off(sum_close_off), .sum_edh(sum_edh),
        .pkt_ready(pkt_ready), .pkt_len(pkt_len), .allow_hanc(allow_hanc),
        .allow_vanc(allow_vanc), .ins_start(ins_start), .ins_busy(ins_busy),
        .ins_vanc(ins_vanc), .ins_off(ins_off), .pending(pending)
    );

    always @(negedge clk) begin
        if (ins_start) begin
            n_starts++;
            rec_hpos = last_hpos;
            rec_off  = int'(ins_off);
            rec_vanc = int'(ins_vanc);
        end
        if (ins_busy) busy_run++;
        else if (busy_run != 0) begin
            last_busy = busy_run;
            busy_run  = 0;
        end
        last_hpos = int'(hpos);
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    function automatic int base_of(input bit v);
        return v ? 0 : 1000;
    endfunction

    task automatic run_region(input bit v, input int line, input int rl, input int ce,
                              input bit op, input bit cl, input int co, input bit edh);
        for (int k = 0; k < rl; k++) begin
            @(posedge clk); #1;
            in_region = 1'b1; region_is_vanc = v; line_num = 11'(line);
            hpos = 12'(base_of(v) + k);
            sum_len = 12'(rl); sum_conf_end = 12'(ce); sum_has_open = op;
            sum_has_close = cl; sum_close_off = 12'(co); sum_edh = edh;
        end
        for (int g = 0; g < 4; g++) begin
            @(posedge clk); #1;
            in_region = 1'b0; hpos = hpos + 12'd1;
        end
        @(negedge clk);
    endtask

    task automatic request(input int len, input bit ah, input bit av);
        @(posedge clk); #1;
        pkt_ready = 1'b1; pkt_len = 10'(len); allow_hanc = ah; allow_vanc = av;
        @(posedge clk); #1;
        pkt_ready = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        summary();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R11 reset start", int'(ins_start), 0);
        check("R11 reset busy", int'(ins_busy), 0);
        check("R11 reset pending", int'(pending), 0);
        @(posedge clk); #1 rst = 1'b0;

        // Sweep over R1/R2/R4 boundaries
        for (int ce = 0; ce <= 20; ce += 10)
        for (int ed = 0; ed < 2; ed++)
        for (int cl = 0; cl < 2; cl++)
        for (int d = -1; d <= 1; d++) begin
            int org, fr, ln;
            org = cl ? ce + 4 : ce;
            fr  = 48 - org - (ed ? EDHW : 0);
            if (fr < 0) fr = 0;
            ln = fr + d;
            if (ln < 1) continue;
            request(ln, 1'b1, 1'b0);
            n_starts = 0;
            run_region(1'b0, 3, 48, ce, 1'b0, cl[0], ce + 4, ed[0]);
            if (ln <= fr) begin
                check("R1 fit accepted", n_starts, 1);
                check("R2 start position", rec_hpos, 1000 + org);
                check("R8 reported offset", rec_off, org);
                check("R9 busy length", last_busy, ln);
                check("R4 EDH-aware accept", int'(pending), 0);
            end else begin
                check("R1 overflow refused", n_starts, 0);
                check("R7 still pending", int'(pending), 1);
                run_region(1'b0, 4, 300, 0, 1'b0, 1'b0, 0, 1'b0);
                check("R7 retried later", n_starts, 1);
                check("R7 retry position", rec_hpos, 1000);
            end
        end

        // R3: open start-marker without end-marker
        request(1, 1'b1, 1'b0);
        n_starts = 0;
        run_region(1'b0, 3, 48, 5, 1'b1, 1'b0, 0, 1'b0);
        check("R3 no space after start-marker", n_starts, 0);
        run_region(1'b0, 4, 48, 5, 1'b1, 1'b1, 30, 1'b0);
        check("R3 closed by end-marker", rec_hpos, 1030);

        // R5: keep-out areas
        request(8, 1'b1, 1'b1);
        n_starts = 0;
        run_region(1'b1, SWL, 100, 0, 1'b0, 1'b0, 0, 1'b0);
        check("R5 vertical keep-out", n_starts, 0);
        run_region(1'b0, SWL + 1, 100, 0, 1'b0, 1'b0, 0, 1'b0);
        check("R5 horizontal keep-out", n_starts, 0);
        run_region(1'b1, SWL + 1, 100, 0, 1'b0, 1'b0, 0, 1'b0);
        check("R5 next vertical region used", n_starts, 1);
        check("R5 vertical kind", rec_vanc, 1);

        // R6: permission and fallback
        request(10, 1'b1, 1'b0);
        n_starts = 0;
        run_region(1'b1, 5, 48, 0, 1'b0, 1'b0, 0, 1'b0);
        check("R6 vertical not permitted", n_starts, 0);
        run_region(1'b0, 6, 48, 0, 1'b0, 1'b0, 0, 1'b0);
        check("R6 horizontal used", rec_vanc * 10 + n_starts, 1);
        request(100, 1'b1, 1'b1);
        n_starts = 0;
        run_region(1'b0, 13, 48, 0, 1'b0, 1'b0, 0, 1'b0);
        check("R6 too long for horizontal", n_starts, 0);
        run_region(1'b1, 13, 200, 12, 1'b0, 1'b0, 0, 1'b0);
        check("R6 fallback to vertical", rec_vanc, 1);
        check("R6 fallback position", rec_hpos, 12);
        check("R9 long packet busy", last_busy, 100);

        // R10: strobes ignored while pending / busy / zero length
        request(10, 1'b1, 1'b0);
        request(30, 1'b1, 1'b0);
        run_region(1'b0, 7, 100, 0, 1'b0, 1'b0, 0, 1'b0);
        check("R10 pending strobe ignored", last_busy, 10);
        request(40, 1'b1, 1'b0);
        fork
            run_region(1'b0, 8, 100, 0, 1'b0, 1'b0, 0, 1'b0);
            begin
                repeat (6) @(posedge clk); #1;
                pkt_ready = 1'b1; pkt_len = 10'd7;
                @(posedge clk); #1 pkt_ready = 1'b0;
            end
        join
        check("R10 busy strobe ignored", int'(pending), 0);
        request(0, 1'b1, 1'b1);
        @(negedge clk);
        check("R10 zero length ignored", int'(pending), 0);

        // R11: reset drops a pending request
        request(5, 1'b1, 1'b0);
        @(negedge clk);
        check("R11 request pending", int'(pending), 1);
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        check("R11 reset clears pending", int'(pending), 0);
        n_starts = 0;
        run_region(1'b0, 9, 48, 0, 1'b0, 1'b0, 0, 1'b0);
        check("R11 nothing inserted after reset", n_starts, 0);

        summary();
    end

endmodule